// File: doc/BRIEF.md
# Card Clock Divider and Gate

This block makes the clock that drives a memory-card bus. It picks one of two source tick streams, counts the ticks with a programmable one-based divider and toggles the card clock each time the count expires. The stream is derived from the block's own module clock, with source 0 firing on every cycle and source 1 qualified by an external tick input. Three phase-selected copies of the card clock come out, for the core, transmit and receive sampling points. Each copy is either in phase with the card clock or inverted, which is 180 degrees.

Software drives one 32-bit clock control word, a stop request, a double-data-rate flag and an indication that a command is in flight. Changes to the source, divisor or phase fields take effect only while the clock is stopped. Stopping takes effect only on a falling edge of the card clock. Because of these two rules, no runt pulse or shortened phase ever reaches the card. A registered strobe marks each clock edge that the data path should act on, and a status output tells whether the clock is running.

All pins are plain control and status signals. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `ccg_card_clock`

## Requirements
- R1: While reset is held, `card_clk`, `clk_stb` and `clk_running` are 0. The active settings are: divisor 63 (all six divisor bits set), source 0, core phase code 2 (so `core_clk_out` is 1), and transmit and receive phase code 0 (so `tx_clk_out` and `rx_clk_out` are 0).
- R2: The divisor field is `ctrl_word[5:0]` and is one-based. With divisor N, the card clock changes level every N ticks of the selected source, so one period is 2N ticks and the high phase is N ticks.
- R3: The source field is `ctrl_word[7:6]`. Code 0 ticks on every module clock cycle. Code 1 ticks only on cycles where `alt_tick` is 1.
- R4: A source code of 2 or 3 is invalid and keeps the clock stopped, with `card_clk` low.
- R5: A divisor of 0 keeps the clock stopped, with `card_clk` low.
- R6: A stop request (`stop_req`, an invalid source, a zero divisor, or automatic gating) that arrives while the clock is running lets the current high phase finish at full length. The clock then stops on the falling edge, and `clk_running` drops in the same cycle that `card_clk` falls.
- R7: When every stop cause is removed while stopped, `clk_running` rises one cycle later. The first rising edge of the card clock comes after N more source ticks.
- R8: Writes to the divisor, source or phase fields while the clock runs do not change its output. They are applied at the next stopped point.
- R9: Bit 16 of `ctrl_word` is the always-on control. When it is 0 and `cmd_active` is 0, the clock is gated as a stop cause. When it is 1, the clock runs regardless of `cmd_active`.
- R10: The phase fields are core `[9:8]`, transmit `[11:10]` and receive `[13:12]`. Bit 1 of a field selects inversion (180 degrees), and bit 0 is ignored, so codes 2 and 3 invert while codes 0 and 1 pass the clock through.
- R11: `clk_stb` is high for one cycle in the cycle in which `card_clk` has just changed. It marks only rising edges when `ddr_mode` is 0, and both edges when `ddr_mode` is 1. This gives one strobe per period in single-rate mode and two in double-rate mode.
- R12: `clk_running` is 1 exactly while the divider is producing the clock. `card_clk` is never high while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_tick | input | 1 | Tick qualifier for source 1 |
| ctrl_word | input | 32 | Clock control word (divisor, source, phases, always-on) |
| stop_req | input | 1 | Stop the card clock at its next falling edge |
| ddr_mode | input | 1 | Double-data-rate mode, strobe on both edges |
| cmd_active | input | 1 | A command is in flight (used when always-on is 0) |
| card_clk | output | 1 | Divided card clock |
| core_clk_out | output | 1 | Core-phase copy of the card clock |
| tx_clk_out | output | 1 | Transmit-phase copy of the card clock |
| rx_clk_out | output | 1 | Receive-phase copy of the card clock |
| clk_stb | output | 1 | One-cycle strobe at each active clock edge |
| clk_running | output | 1 | Card clock is running |

## Verification
Two functions can fall in the same cycle: a stop request and the divider's terminal count on a high phase. In that cycle the falling edge, the drop of `clk_running` and, in double-rate mode, a strobe all land together. The bench provokes this by raising `stop_req` just after a rising edge. It then judges that the high phase still lasts the full N samples and that `clk_running` is already 0 in the first low sample. A second collision comes from rewriting the divisor while the clock runs and then stopping it. The bench checks that the old period holds until the stop and that the new one appears only after the restart.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  // Bit position of the always-on control inside the control word
  localparam int unsigned AON_BIT = 16;
  // Phase field order: core, transmit, receive
  localparam int unsigned PH_CORE = 0;
  localparam int unsigned PH_TX   = 1;
  localparam int unsigned PH_RX   = 2;

  // A phase code inverts the clock when its upper bit is set
  function automatic logic ph_invert(input logic [1:0] code);
    return code[1];
  endfunction
endpackage

// File: rtl/ccg_src_sel.sv
module ccg_src_sel #(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned SEL_W   = 2
) (
  input  logic [NUM_SRC-1:0] src_ticks,
  input  logic [SEL_W-1:0]   sel,
  output logic               tick
);
  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == SEL_W'(i)) tick = src_ticks[i];
    end
  end
endmodule

// File: rtl/ccg_divider.sv
module ccg_divider #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  input  logic             halt,
  input  logic             ddr,
  output logic             clk_o,
  output logic             stb,
  output logic             running
);
  logic [DIV_W-1:0] cnt;
  logic             last;

  assign last = (cnt == div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      clk_o   <= 1'b0;
      stb     <= 1'b0;
    end else begin
      stb <= 1'b0;
      if (!running) begin
        cnt   <= '0;
        clk_o <= 1'b0;
        if (!halt) running <= 1'b1;
      end else if (tick) begin
        if (last) begin
          cnt   <= '0;
          clk_o <= ~clk_o;
          stb   <= ~clk_o | ddr;
          if (clk_o && halt) running <= 1'b0;
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ccg_card_clock.sv
module ccg_card_clock #(
  parameter int unsigned DIV_W   = 6,
  parameter int unsigned SRC_W   = 2,
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned PH_W    = 2,
  parameter int unsigned NUM_PH  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alt_tick,
  input  logic [31:0] ctrl_word,
  input  logic        stop_req,
  input  logic        ddr_mode,
  input  logic        cmd_active,
  output logic        card_clk,
  output logic        core_clk_out,
  output logic        tx_clk_out,
  output logic        rx_clk_out,
  output logic        clk_stb,
  output logic        clk_running
);
  import ccg_pkg::*;

  localparam int unsigned SRC_LSB = DIV_W;
  localparam int unsigned PH_LSB  = SRC_LSB + SRC_W;
  localparam int unsigned PH_BITS = PH_W * NUM_PH;
  localparam logic [PH_BITS-1:0] PH_RESET = PH_BITS'(2) << (PH_CORE * PH_W);

  logic [DIV_W-1:0]   new_div, act_div;
  logic [SRC_W-1:0]   new_src, act_src;
  logic [PH_BITS-1:0] new_ph, act_ph;
  logic               halt_req, tick;
  logic [NUM_PH-1:0]  ph_out;
  logic               unused_ctrl;

  assign new_div = ctrl_word[DIV_W-1:0];
  assign new_src = ctrl_word[SRC_LSB +: SRC_W];
  assign new_ph  = ctrl_word[PH_LSB +: PH_BITS];
  assign unused_ctrl = ^{ctrl_word[31:AON_BIT+1], ctrl_word[AON_BIT-1:PH_LSB+PH_BITS]};

  assign halt_req = stop_req
                  | (!ctrl_word[AON_BIT] && !cmd_active)
                  | (new_div == '0)
                  | (new_src >= SRC_W'(NUM_SRC));

  // Settings are taken over only while the clock is stopped
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_div <= '1;
      act_src <= '0;
      act_ph  <= PH_RESET;
    end else if (!clk_running) begin
      act_div <= new_div;
      act_src <= new_src;
      act_ph  <= new_ph;
    end
  end

  ccg_src_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SRC_W)) u_src (
    .src_ticks ({alt_tick, 1'b1}),
    .sel       (act_src),
    .tick      (tick)
  );

  ccg_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .div     (act_div),
    .halt    (halt_req),
    .ddr     (ddr_mode),
    .clk_o   (card_clk),
    .stb     (clk_stb),
    .running (clk_running)
  );

  for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
    assign ph_out[g] = card_clk ^ ph_invert(act_ph[g*PH_W +: PH_W]);
  end

  assign core_clk_out = ph_out[PH_CORE];
  assign tx_clk_out   = ph_out[PH_TX];
  assign rx_clk_out   = ph_out[PH_RX];
endmodule

// File: rtl/ccg_card_clock_chk.sv
module ccg_card_clock_chk #(
  parameter int unsigned DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ddr_mode,
  input logic             card_clk,
  input logic             clk_stb,
  input logic             clk_running,
  input logic [DIV_W-1:0] act_div
);
  // R6: stopping happens only on a falling edge
  a_r6_stop_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_running) |-> (!card_clk && $past(card_clk)));

  // R12: no clock output while not running
  a_r12_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_running |-> !card_clk);

  // R11: strobe marks a level change
  a_r11_stb_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stb |-> (card_clk != $past(card_clk)));

  // R11: single-rate strobe only on rising edges
  a_r11_sdr_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stb && !$past(ddr_mode)) |-> card_clk);

  // R8: divisor frozen while the clock runs
  a_r8_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_running && $past(clk_running)) |-> $stable(act_div));
endmodule

bind ccg_card_clock ccg_card_clock_chk #(.DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ddr_mode    (ddr_mode),
  .card_clk    (card_clk),
  .clk_stb     (clk_stb),
  .clk_running (clk_running),
  .act_div     (act_div)
);

// File: tb/ccg_card_clock_test.sv
module ccg_card_clock_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alt_tick = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic        stop_req = 1'b1;
  logic        ddr_mode = 1'b0;
  logic        cmd_active = 1'b0;
  logic        card_clk, core_clk_out, tx_clk_out, rx_clk_out, clk_stb, clk_running;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int alt_cnt = 0;

  ccg_card_clock uut (
    .clk(clk), .rst_n(rst_n), .alt_tick(alt_tick), .ctrl_word(ctrl_word),
    .stop_req(stop_req), .ddr_mode(ddr_mode), .cmd_active(cmd_active),
    .card_clk(card_clk), .core_clk_out(core_clk_out), .tx_clk_out(tx_clk_out),
    .rx_clk_out(rx_clk_out), .clk_stb(clk_stb), .clk_running(clk_running)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // alt_tick fires every third cycle
  always @(negedge clk) begin
    alt_cnt  = (alt_cnt + 1) % 3;
    alt_tick = (alt_cnt == 0);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected below %0d", cyc, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] mk(int dv, int src, int core, int tx, int rx, int aon);
    return 32'(dv) | (32'(src) << 6) | (32'(core) << 8) | (32'(tx) << 10)
         | (32'(rx) << 12) | (32'(aon) << 16);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic halt_clock();
    stop_req = 1'b1;
    for (int i = 0; i < 2000 && clk_running; i++) @(negedge clk);
  endtask

  task automatic start_with(input logic [31:0] w);
    halt_clock();
    ctrl_word = w;
    @(negedge clk);
    stop_req = 1'b0;
  endtask

  // Measures one full period from a rising edge: samples, high samples, strobes
  task automatic measure(output int per, output int hi, output int stb);
    logic prev;
    prev = card_clk;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!prev && card_clk) break;
      prev = card_clk;
    end
    per = 0; hi = 0; stb = 0;
    for (int i = 0; i < 4000; i++) begin
      per++;
      if (card_clk) hi++;
      if (clk_stb) stb++;
      prev = card_clk;
      @(negedge clk);
      if (!prev && card_clk) break;
    end
  endtask

  initial begin
    int per, hi, stb, k, bad;
    ctrl_word = 32'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(card_clk == 0 && clk_stb == 0 && clk_running == 0, "R1 outputs", card_clk, 0);
    check(core_clk_out == 1 && tx_clk_out == 0 && rx_clk_out == 0, "R1 phases",
          {core_clk_out, tx_clk_out, rx_clk_out}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: sweep divisor with source 0, also R11 single-rate strobe count
    for (int n = 1; n <= 8; n++) begin
      start_with(mk(n, 0, 0, 0, 0, 1));
      measure(per, hi, stb);
      check(per == 2*n, "R2 period", per, 2*n);
      check(hi == n, "R2 high phase", hi, n);
      check(stb == 1, "R11 sdr strobes", stb, 1);
      check(clk_running == 1, "R12 running", clk_running, 1);
    end

    // R11: double-rate strobes
    ddr_mode = 1'b1;
    for (int n = 1; n <= 4; n++) begin
      start_with(mk(n, 0, 0, 0, 0, 1));
      measure(per, hi, stb);
      check(stb == 2, "R11 ddr strobes", stb, 2);
      check(per == 2*n, "R2 ddr period", per, 2*n);
    end
    ddr_mode = 1'b0;

    // R3: source 1 ticks on alt_tick (every third cycle)
    for (int n = 1; n <= 3; n++) begin
      start_with(mk(n, 1, 0, 0, 0, 1));
      measure(per, hi, stb);
      check(per == 6*n, "R3 alt source period", per, 6*n);
      check(hi == 3*n, "R3 alt source high", hi, 3*n);
    end

    // R4: invalid source codes
    for (int s = 2; s <= 3; s++) begin
      start_with(mk(3, s, 0, 0, 0, 1));
      k = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (clk_running || card_clk) k++;
      end
      check(k == 0, "R4 invalid source stays stopped", k, 0);
    end

    // R5: divisor zero
    start_with(mk(0, 0, 0, 0, 0, 1));
    k = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (clk_running || card_clk) k++;
    end
    check(k == 0, "R5 zero divisor stays stopped", k, 0);

    // R7: restart latency
    for (int n = 1; n <= 6; n++) begin
      halt_clock();
      ctrl_word = mk(n, 0, 0, 0, 0, 1);
      @(negedge clk);
      stop_req = 1'b0;
      @(negedge clk);
      check(clk_running == 1, "R7 running one cycle later", clk_running, 1);
      k = 1;
      while (!card_clk && k < 200) begin @(negedge clk); k++; end
      check(k == n + 1, "R7 first rise", k, n + 1);
    end

    // R6: stop mid-high keeps full high phase, stops on the fall
    for (int n = 2; n <= 5; n++) begin
      start_with(mk(n, 0, 0, 0, 0, 1));
      measure(per, hi, stb);
      stop_req = 1'b1;
      hi = 1;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (card_clk) hi++; else break;
      end
      check(hi == n, "R6 high phase completes", hi, n);
      check(clk_running == 0, "R6 stopped with the fall", clk_running, 0);
    end

    // R8: divisor write while running is deferred
    start_with(mk(3, 0, 0, 0, 0, 1));
    measure(per, hi, stb);
    ctrl_word = mk(5, 0, 2, 2, 2, 1);
    measure(per, hi, stb);
    check(per == 6, "R8 old period holds", per, 6);
    check(tx_clk_out == card_clk, "R8 phase write deferred", tx_clk_out, card_clk);
    halt_clock();
    @(negedge clk);
    stop_req = 1'b0;
    measure(per, hi, stb);
    check(per == 10, "R8 new period after stop", per, 10);

    // R9: automatic gating when always-on is clear
    start_with(mk(2, 0, 0, 0, 0, 0));
    cmd_active = 1'b0;
    repeat (20) @(negedge clk);
    check(clk_running == 0, "R9 gated without command", clk_running, 0);
    cmd_active = 1'b1;
    measure(per, hi, stb);
    check(per == 4, "R9 runs during command", per, 4);
    cmd_active = 1'b0;
    repeat (10) @(negedge clk);
    check(clk_running == 0 && card_clk == 0, "R9 gated after command", clk_running, 0);

    // R10: phase selection, bit 0 ignored
    start_with(mk(3, 0, 1, 2, 3, 1));
    measure(per, hi, stb);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (core_clk_out != card_clk) bad++;
      if (tx_clk_out != !card_clk) bad++;
      if (rx_clk_out != !card_clk) bad++;
    end
    check(bad == 0, "R10 phase outputs", bad, 0);
    halt_clock();
    @(negedge clk);
    check(card_clk == 0 && clk_running == 0, "R12 stopped low", card_clk, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule